// File: doc/BRIEF.md
# Dynamic bus sizing sequencer

This block sits between a processor-side request port and a 16-bit external memory bus. A request carries an operand of one, two or four bytes, a start byte address, an area number, a read/write flag and write data. The block looks up the area's settings: an enable bit and a width bit that marks the area as 8 or 16 bits wide. It then breaks the operand into as many external bus cycles as the area width and the address alignment call for.

In each bus cycle the block drives the cycle address, the set of active byte lanes, the lane output enables and the write strobes. Lanes that carry no operand byte are left undriven and unstrobed. On reads, the bytes returned on the active lanes are merged into the operand, and the finished operand is presented with a one-clock done pulse. A request to a disabled area starts no bus cycle and completes at once with zero data. Area settings are written through a small configuration port. After reset, only area 2 is enabled.

Top module: `bsz_sequencer`

## Requirements
- R1: After reset, areas 0, 1 and 3 are disabled, area 2 is enabled and every area is 16 bits wide. The block is idle with `req_ready`=1, `bus_req`=0, `done`=0 and `bus_lane_en`=0.
- R2: A configuration write (`cfg_we`=1) loads area `cfg_area`. Bit 7 of `cfg_data` is the enable, and bit 3 selects the width (1 = 8-bit area, 0 = 16-bit area). The new settings apply only to requests accepted after that clock edge. A request accepted in the same cycle as the write uses the previous settings.
- R3: A request to a disabled area starts no bus cycle. `done` is 1 in the clock after acceptance, with `rdata`=0.
- R4: On an 8-bit area, an operand of n bytes takes n cycles at consecutive byte addresses, least significant byte first. Every byte uses the low lane only (`bus_lane_en`=2'b01).
- R5: On a 16-bit area, a byte operand takes one cycle. It uses lane 0 (`bus_lane_en`=2'b01, D7..D0) at an even address and lane 1 (2'b10, D15..D8) at an odd address.
- R6: On a 16-bit area, an even 16-bit operand takes one cycle with both lanes active. An odd one at address a takes two cycles: at a, byte 0 on lane 1; then at a+1, byte 1 on lane 0.
- R7: On a 16-bit area, an even 32-bit operand at a takes two cycles, at a and a+2, each with both lanes active. An odd one takes three cycles: at a, byte 0 on lane 1; at a+1, byte 1 on lane 0 and byte 2 on lane 1; at a+3, byte 3 on lane 0.
- R8: `bus_oe` and `bus_wstb` equal `bus_lane_en` during write cycles and are 0 on reads and when no cycle is active. On an active write lane, `bus_dout` carries the operand byte assigned to that lane.
- R9: Read data returned on inactive lanes is ignored. `rdata` holds operand byte i in bits 8i+7..8i, with unused upper bytes 0. A completed write reports `rdata`=0.
- R10: `req_ready` is 1 only while idle. Bus outputs are held until `bus_ack` is sampled high, which ends the cycle. The next cycle, or the one-clock `done` pulse, follows in the next clock. A new request can be accepted in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_size | input | 2 | Operand size: 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Operand start byte address |
| req_area | input | AREA_W | Address area number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, byte 0 in bits 7..0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand, valid with done |
| cfg_we | input | 1 | Area settings write |
| cfg_area | input | AREA_W | Area being configured |
| cfg_data | input | 8 | Settings: bit 7 enable, bit 3 8-bit width |
| bus_req | output | 1 | External cycle active |
| bus_addr | output | ADDR_W | Byte address of the cycle's first active lane |
| bus_lane_en | output | 2 | Active lanes: bit 0 D7..D0, bit 1 D15..D8 |
| bus_oe | output | 2 | Per-lane output drive enable |
| bus_wstb | output | 2 | Per-lane write strobe |
| bus_dout | output | 16 | Write data on the lanes |
| bus_din | input | 16 | Read data from the lanes |
| bus_ack | input | 1 | Memory acknowledge ending the current cycle |

## Verification
Two functions can fall in the same clock: a settings write and the acceptance of a request to the same area. The bench raises `cfg_we` and `req_valid` together, once to enable a disabled area and once to switch an 8-bit area to 16 bits. It then judges from the bus cycles, or from their absence, that the accepted request still followed the old settings and that the next request followed the new ones. Requests are also chained so that each one is accepted in the clock of the previous done pulse. Acknowledge delays vary, which shows that the outputs hold steady while the bus waits.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int OP_BYTES  = 4;
    localparam int OP_W      = 8 * OP_BYTES;
    localparam int LANES     = 2;
    localparam int BUS_W     = 8 * LANES;
    localparam int CNT_W     = $clog2(OP_BYTES + 1);
    localparam int IDX_W     = $clog2(OP_BYTES);
    localparam int CFG_EN_BIT = 7;
    localparam int CFG_W8_BIT = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_state_e;

    function automatic logic [CNT_W-1:0] op_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/bsz_area_cfg.sv
module bsz_area_cfg
    import bsz_pkg::*;
#(
    parameter int AREA_W = 2,
    parameter logic [(1<<AREA_W)-1:0] EN_RST = 4'b0100,
    parameter logic [(1<<AREA_W)-1:0] W8_RST = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [AREA_W-1:0]        cfg_area,
    input  logic [7:0]               cfg_data,
    output logic [(1<<AREA_W)-1:0]   area_en,
    output logic [(1<<AREA_W)-1:0]   area_w8
);
    localparam int NUM_AREAS = 1 << AREA_W;

    typedef struct packed {
        logic [NUM_AREAS-1:0] en;
        logic [NUM_AREAS-1:0] w8;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int a = 0; a < NUM_AREAS; a++) begin
            if (cfg_we && (cfg_area == AREA_W'(a))) begin
                cfg_d.en[a] = cfg_data[CFG_EN_BIT];
                cfg_d.w8[a] = cfg_data[CFG_W8_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en <= EN_RST;
            cfg_q.w8 <= W8_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign area_en = cfg_q.en;
    assign area_w8 = cfg_q.w8;

endmodule

// File: rtl/bsz_lane_plan.sv
module bsz_lane_plan
    import bsz_pkg::*;
(
    input  logic             width8,
    input  logic             addr_odd,
    input  logic [CNT_W-1:0] remain,
    input  logic [IDX_W-1:0] idx,
    output logic [LANES-1:0] lanes,
    output logic [CNT_W-1:0] step,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx
);
    always_comb begin
        lo_idx = idx;
        hi_idx = idx;
        if (width8) begin
            lanes = 2'b01;
            step  = CNT_W'(1);
        end else if (addr_odd) begin
            lanes = 2'b10;
            step  = CNT_W'(1);
        end else if (remain >= CNT_W'(2)) begin
            lanes  = 2'b11;
            step   = CNT_W'(2);
            hi_idx = idx + IDX_W'(1);
        end else begin
            lanes = 2'b01;
            step  = CNT_W'(1);
        end
    end

endmodule

// File: rtl/bsz_data_steer.sv
module bsz_data_steer
    import bsz_pkg::*;
(
    input  logic             write,
    input  logic [LANES-1:0] lanes,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] hi_idx,
    input  logic [OP_W-1:0]  wdata,
    input  logic [BUS_W-1:0] din,
    input  logic [OP_W-1:0]  rd_cur,
    output logic [BUS_W-1:0] dout,
    output logic [OP_W-1:0]  rd_next
);
    logic [7:0] wbyte_lo, wbyte_hi;

    assign wbyte_lo = wdata[{lo_idx, 3'b000} +: 8];
    assign wbyte_hi = wdata[{hi_idx, 3'b000} +: 8];

    assign dout[7:0]  = (write && lanes[0]) ? wbyte_lo : 8'h00;
    assign dout[15:8] = (write && lanes[1]) ? wbyte_hi : 8'h00;

    for (genvar b = 0; b < OP_BYTES; b++) begin : g_merge
        assign rd_next[8*b +: 8] =
            (lanes[0] && (lo_idx == IDX_W'(b))) ? din[7:0]  :
            (lanes[1] && (hi_idx == IDX_W'(b))) ? din[15:8] :
                                                  rd_cur[8*b +: 8];
    end

endmodule

// File: rtl/bsz_sequencer.sv
module bsz_sequencer
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AREA_W = 2,
    parameter logic [(1<<AREA_W)-1:0] AREA_EN_RST = 4'b0100,
    parameter logic [(1<<AREA_W)-1:0] AREA_W8_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rdata,
    input  logic              cfg_we,
    input  logic [AREA_W-1:0] cfg_area,
    input  logic [7:0]        cfg_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_lane_en,
    output logic [1:0]        bus_oe,
    output logic [1:0]        bus_wstb,
    output logic [15:0]       bus_dout,
    input  logic [15:0]       bus_din,
    input  logic              bus_ack
);
    localparam int NUM_AREAS = 1 << AREA_W;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  rem;
        logic              w8;
        logic              wr;
        logic [OP_W-1:0]   wdata;
        logic [OP_W-1:0]   rdata;
        logic              done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [NUM_AREAS-1:0] area_en, area_w8;
    logic [LANES-1:0]     lanes;
    logic [CNT_W-1:0]     step;
    logic [IDX_W-1:0]     lo_idx, hi_idx;
    logic [BUS_W-1:0]     steer_dout;
    logic [OP_W-1:0]      rd_merged;
    logic                 busy;

    bsz_area_cfg #(
        .AREA_W (AREA_W),
        .EN_RST (AREA_EN_RST),
        .W8_RST (AREA_W8_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_area (cfg_area),
        .cfg_data (cfg_data),
        .area_en  (area_en),
        .area_w8  (area_w8)
    );

    bsz_lane_plan u_plan (
        .width8   (ctx_q.w8),
        .addr_odd (ctx_q.addr[0]),
        .remain   (ctx_q.rem),
        .idx      (ctx_q.idx),
        .lanes    (lanes),
        .step     (step),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx)
    );

    bsz_data_steer u_steer (
        .write   (ctx_q.wr),
        .lanes   (lanes),
        .lo_idx  (lo_idx),
        .hi_idx  (hi_idx),
        .wdata   (ctx_q.wdata),
        .din     (bus_din),
        .rd_cur  (ctx_q.rdata),
        .dout    (steer_dout),
        .rd_next (rd_merged)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.rdata = '0;
                    if (area_en[req_area]) begin
                        ctx_d.st    = ST_BUS;
                        ctx_d.addr  = req_addr;
                        ctx_d.idx   = '0;
                        ctx_d.rem   = op_bytes(req_size);
                        ctx_d.w8    = area_w8[req_area];
                        ctx_d.wr    = req_write;
                        ctx_d.wdata = req_wdata;
                    end else begin
                        ctx_d.done  = 1'b1;
                    end
                end
            end
            ST_BUS: begin
                if (bus_ack) begin
                    if (!ctx_q.wr) begin
                        ctx_d.rdata = rd_merged;
                    end
                    ctx_d.addr = ctx_q.addr + ADDR_W'(step);
                    ctx_d.idx  = ctx_q.idx + IDX_W'(step);
                    ctx_d.rem  = ctx_q.rem - step;
                    if (ctx_q.rem == step) begin
                        ctx_d.st   = ST_IDLE;
                        ctx_d.done = 1'b1;
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy        = (ctx_q.st == ST_BUS);
    assign req_ready   = !busy;
    assign bus_req     = busy;
    assign bus_addr    = ctx_q.addr;
    assign bus_lane_en = busy ? lanes : 2'b00;
    assign bus_oe      = (busy && ctx_q.wr) ? lanes : 2'b00;
    assign bus_wstb    = (busy && ctx_q.wr) ? lanes : 2'b00;
    assign bus_dout    = busy ? steer_dout : 16'h0000;
    assign done        = ctx_q.done;
    assign rdata       = ctx_q.rdata;

endmodule

// File: rtl/bsz_sequencer_chk.sv
module bsz_sequencer_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_lane_en,
    input logic [1:0]        bus_oe,
    input logic [1:0]        bus_wstb,
    input logic [15:0]       bus_dout,
    input logic              bus_ack
);
    // R10: no acceptance while a bus cycle runs
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    // R10: outputs hold until acknowledge
    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_lane_en) && $stable(bus_dout)));

    // R10: done follows either a final acknowledge or an immediate completion
    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_req && bus_ack) || $past(req_valid && req_ready)));

    // R8: drive and strobe only on active lanes
    p_lane_gating_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_oe & ~bus_lane_en) == 2'b00) && ((bus_wstb & ~bus_lane_en) == 2'b00));

    // R8: nothing driven outside a cycle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_lane_en == 2'b00 && bus_oe == 2'b00 && bus_wstb == 2'b00));

    // R4: every active cycle moves at least one byte
    p_cycle_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_lane_en != 2'b00));

endmodule

bind bsz_sequencer bsz_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_lane_en (bus_lane_en),
    .bus_oe      (bus_oe),
    .bus_wstb    (bus_wstb),
    .bus_dout    (bus_dout),
    .bus_ack     (bus_ack)
);

// File: tb/bsz_sequencer_test.sv
module bsz_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_area = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_area = '0;
    logic [7:0]  cfg_data = '0;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic [1:0]  bus_lane_en, bus_oe, bus_wstb;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ack = 1'b0;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mem [256];

    typedef struct {
        int       addr;
        bit [1:0] lanes;
        int       lo;
        int       hi;
    } cyc_t;

    cyc_t exp_q[$];

    always #5 clk = ~clk;

    bsz_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
        .req_addr(req_addr), .req_area(req_area), .req_write(req_write),
        .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_data(cfg_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_lane_en(bus_lane_en),
        .bus_oe(bus_oe), .bus_wstb(bus_wstb), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic do_req(input int area, input int size, input int addr,
                          input bit wr, input logic [31:0] wd,
                          input bit en, input bit w8, input int waits,
                          input bit cfg_now, input int cfg_a, input logic [7:0] cfg_v);
        int n;
        string tag;
        logic [31:0] exp_rd;
        cyc_t c;
        bit have;
        n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        tag = w8 ? "R4" : (size == 0) ? "R5" : (size == 1) ? "R6" : "R7";
        exp_q.delete();
        have = 0;
        c = '{0, 2'b00, 0, 0};
        for (int i = 0; i < n; i++) begin
            int a;
            a = addr + i;
            if (!have || w8 || ((c.addr >> 1) != (a >> 1))) begin
                if (have) exp_q.push_back(c);
                c = '{a, 2'b00, 0, 0};
                have = 1;
            end
            if (w8 || (a % 2 == 0)) begin c.lanes[0] = 1'b1; c.lo = i; end
            else                    begin c.lanes[1] = 1'b1; c.hi = i; end
        end
        exp_q.push_back(c);
        exp_rd = '0;
        for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mem[(addr + i) & 255];

        chk(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_size = 2'(size); req_addr = 24'(addr);
        req_area = 2'(area); req_write = wr; req_wdata = wd;
        cfg_we = cfg_now; cfg_area = 2'(cfg_a); cfg_data = cfg_v;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;

        if (!en) begin
            chk(done == 1'b1, "R3", "done on disabled area", 32'(done), 1);
            chk(rdata == 32'h0, "R3", "rdata on disabled area", rdata, 0);
            chk(bus_req == 1'b0, "R3", "no bus cycle on disabled area", 32'(bus_req), 0);
            return;
        end

        while (exp_q.size() > 0) begin
            cyc_t e;
            e = exp_q.pop_front();
            for (int w = 0; w <= waits; w++) begin
                chk(bus_req == 1'b1, "R10", "bus cycle active", 32'(bus_req), 1);
                chk(req_ready == 1'b0, "R10", "ready low while busy", 32'(req_ready), 0);
                chk(done == 1'b0, "R10", "no done mid sequence", 32'(done), 0);
                chk(bus_addr == 24'(e.addr), tag, "cycle address", 32'(bus_addr), 32'(e.addr));
                chk(bus_lane_en == e.lanes, tag, "lane enables", 32'(bus_lane_en), 32'(e.lanes));
                chk(bus_oe == (wr ? e.lanes : 2'b00), "R8", "lane output enables",
                    32'(bus_oe), 32'(wr ? e.lanes : 2'b00));
                chk(bus_wstb == (wr ? e.lanes : 2'b00), "R8", "write strobes",
                    32'(bus_wstb), 32'(wr ? e.lanes : 2'b00));
                if (wr && e.lanes[0])
                    chk(bus_dout[7:0] == wd[8*e.lo +: 8], "R8", "low lane write byte",
                        32'(bus_dout[7:0]), 32'(wd[8*e.lo +: 8]));
                if (wr && e.lanes[1])
                    chk(bus_dout[15:8] == wd[8*e.hi +: 8], "R8", "high lane write byte",
                        32'(bus_dout[15:8]), 32'(wd[8*e.hi +: 8]));
                if (w == waits) begin
                    bus_ack = 1'b1;
                    if (w8) bus_din = {8'hA5, mem[e.addr & 255]};
                    else    bus_din = {mem[(e.addr | 1) & 255], mem[(e.addr & ~1) & 255]};
                end else begin
                    bus_ack = 1'b0;
                    bus_din = 16'h5A5A;
                end
                @(negedge clk);
            end
            bus_ack = 1'b0;
            bus_din = 16'h3C3C;
        end
        chk(done == 1'b1, "R10", "done pulse after last cycle", 32'(done), 1);
        chk(bus_req == 1'b0, "R10", "bus idle with done", 32'(bus_req), 0);
        chk(rdata == (wr ? 32'h0 : exp_rd), "R9", "assembled read data",
            rdata, wr ? 32'h0 : exp_rd);
    endtask

    task automatic cfg_write(input int area, input logic [7:0] v);
        cfg_we = 1'b1; cfg_area = 2'(area); cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #2000000;
        nchk++;
        nfail++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
        chk(bus_req == 1'b0, "R1", "bus idle in reset", 32'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "no done after reset", 32'(done), 0);
        chk(bus_lane_en == 2'b00, "R1", "no lanes after reset", 32'(bus_lane_en), 0);

        // R1/R3: reset enables only area 2
        do_req(0, 2, 'h10, 0, 0, 0, 0, 0, 0, 0, 0);
        do_req(1, 0, 'h11, 0, 0, 0, 0, 0, 0, 0, 0);
        do_req(3, 1, 'h12, 1, 32'h1234, 0, 0, 0, 0, 0, 0);
        // R5: byte lanes on a 16-bit area
        do_req(2, 0, 'h20, 0, 0, 1, 0, 0, 0, 0, 0);
        do_req(2, 0, 'h21, 0, 0, 1, 0, 1, 0, 0, 0);
        do_req(2, 0, 'h23, 1, 32'h000000C7, 1, 0, 0, 0, 0, 0);
        // R6: halfwords
        do_req(2, 1, 'h30, 0, 0, 1, 0, 2, 0, 0, 0);
        do_req(2, 1, 'h31, 0, 0, 1, 0, 0, 0, 0, 0);
        do_req(2, 1, 'h35, 1, 32'h0000BEEF, 1, 0, 1, 0, 0, 0);
        // R7: words
        do_req(2, 2, 'h40, 0, 0, 1, 0, 0, 0, 0, 0);
        do_req(2, 2, 'h43, 0, 0, 1, 0, 3, 0, 0, 0);
        do_req(2, 3, 'h45, 1, 32'hDEADBEEF, 1, 0, 0, 0, 0, 0);
        do_req(2, 2, 'h48, 1, 32'h89ABCDEF, 1, 0, 1, 0, 0, 0);
        // R2/R4: enable area 0 as an 8-bit area
        cfg_write(0, 8'h88);
        do_req(0, 2, 'h51, 0, 0, 1, 1, 0, 0, 0, 0);
        do_req(0, 1, 'h60, 1, 32'h0000A55A, 1, 1, 1, 0, 0, 0);
        do_req(0, 0, 'h63, 0, 0, 1, 1, 0, 0, 0, 0);
        // R2: settings write in the accepting cycle uses old settings
        do_req(1, 2, 'h70, 0, 0, 0, 0, 0, 1, 1, 8'h80);
        do_req(1, 2, 'h71, 0, 0, 1, 0, 0, 0, 0, 0);
        do_req(0, 1, 'h81, 0, 0, 1, 1, 0, 1, 0, 8'h80);
        do_req(0, 1, 'h81, 0, 0, 1, 0, 0, 0, 0, 0);
        // R2/R3: disable area 2
        cfg_write(2, 8'h08);
        do_req(2, 2, 'h90, 1, 32'h11223344, 0, 0, 0, 0, 0, 0);
        do_req(3, 0, 'h91, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done lasts one clock", 32'(done), 0);
        chk(req_ready == 1'b1, "R10", "ready when idle", 32'(req_ready), 1);
        summary();
        $finish;
    end

endmodule